// File: doc/BRIEF.md
# Shared Debug Event Controller

This block arbitrates eight debug resources between an external hardware debugger and software running on the core. Each resource has one event input, one event-enable bit, one ownership bit and one status bit. When the external debugger has switched on its debug mode, a resource stays under exclusive hardware control unless the debugger has handed it to software through an allocation register. Ownership decides what a recorded event does. An event on a hardware-owned resource halts the core. An event on a software-owned resource raises a debug interrupt.

Two register write ports reach the block. One comes from the external debug port, and its strobe only takes effect while a core-clock enable is high. The other comes from software. Software cannot take control away from the debugger. Its writes to the mode bit and the allocation register are dropped, and so are its writes to hardware-owned enable bits and its writes to the internal-mode bit while external mode is on. The status bits are write-one-to-clear from the side that owns each bit. The halt request is held until the debugger writes a resume command.

Top module: `dbg_share_ctrl`

## Requirements
- R1: After reset, status_o, irq_o and halt_o are all zero, and the mode bits, allocation bits and enable bits are all zero.
- R2: While both the external-mode bit and the internal-mode bit are 0, no event changes status_o, irq_o or halt_o.
- R3: The control register is at address 0, with bit 0 for external mode and bit 1 for internal mode. The allocation register is at address 1, the per-resource enable register at address 2, the status clear at address 3 and the resume command at address 4. A software-owned resource records an event in status_o one cycle after the pulse, but only when its enable bit is 1 and the internal-mode bit is 1.
- R4: irq_o is 1 exactly when msr_de is 1, the internal-mode bit is 1 and at least one software-owned status bit is set. It follows msr_de in the same cycle.
- R5: A resource is hardware-owned when external mode is 1 and its allocation bit is 0. An enabled event on such a resource sets its status bit whatever the values of msr_de and the internal-mode bit. It asserts halt_o on the next cycle and never raises irq_o.
- R6: Under external mode, a resource whose allocation bit is 1 behaves as software-owned. Its events go to irq_o and not to halt_o.
- R7: Software writes to the external-mode bit and to the allocation register have no effect.
- R8: While external mode is 1, software writes to the enable bits of hardware-owned resources and to the internal-mode bit have no effect. Software writes to the enable bits of software-owned resources still take effect.
- R9: A write from the external port takes effect only in a cycle where core_clk_en is 1.
- R10: Writing a 1 to a bit at the status address clears that bit only when the write comes from the side that owns the resource. A 1 written from the other side leaves the bit set.
- R11: An event recorded in the same cycle as a clear of its status bit leaves the bit set.
- R12: halt_o stays at 1 until the external port writes the resume address. A new hardware-owned event in the same cycle as the resume keeps halt_o at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_wr_en | input | 1 | External debug port write strobe |
| core_clk_en | input | 1 | Core clock running; qualifies ext_wr_en |
| ext_addr | input | 3 | External write address |
| ext_wdata | input | NUM_RES | External write data |
| sw_wr_en | input | 1 | Software write strobe |
| sw_addr | input | 3 | Software write address |
| sw_wdata | input | NUM_RES | Software write data |
| evt_i | input | NUM_RES | Raw debug event pulses, one per resource |
| msr_de | input | 1 | Software debug-enable bit from machine state |
| status_o | output | NUM_RES | Debug status bits |
| irq_o | output | 1 | Debug interrupt request |
| halt_o | output | 1 | Halt (debug mode entry) request |

## Verification
The bench goes after the places where ownership is split. It uses a mixed allocation mask so that one sweep of events, clears and enable writes reaches hardware-owned and software-owned bits together. A design that decided ownership from the wrong bit would send events to the interrupt when they should halt the core, or clear status bits from the side that does not own them. A design that did not block software would let software writes take back allocation or enable bits. The bench also lines up an event with a clear of the same bit, and a resume with a new hardware event, in one cycle. A design with the wrong priority would lose the event or drop the halt. An external write or resume while the core clock is stopped must leave the state untouched. A design that ignored the clock enable would switch mode or release the halt early.

// File: rtl/dbg_share_pkg.sv
package dbg_share_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_ALLOC  = 3'd1,
        A_ENABLE = 3'd2,
        A_STATUS = 3'd3,
        A_RESUME = 3'd4
    } reg_addr_e;

    localparam int CTRL_EXT_BIT = 0;
    localparam int CTRL_INT_BIT = 1;

endpackage

// File: rtl/dbg_share_regs.sv
module dbg_share_regs
    import dbg_share_pkg::*;
#(
    parameter int NUM_RES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_we,
    input  logic [ADDR_W-1:0]  ext_addr,
    input  logic [NUM_RES-1:0] ext_wdata,
    input  logic               sw_we,
    input  logic [ADDR_W-1:0]  sw_addr,
    input  logic [NUM_RES-1:0] sw_wdata,
    output logic               int_mode,
    output logic [NUM_RES-1:0] hw_own,
    output logic [NUM_RES-1:0] en,
    output logic [NUM_RES-1:0] ext_clr,
    output logic [NUM_RES-1:0] sw_clr,
    output logic               resume
);

    typedef struct packed {
        logic               ext_mode;
        logic               int_mode;
        logic [NUM_RES-1:0] alloc;
        logic [NUM_RES-1:0] en;
    } regs_t;

    regs_t r_d, r_q;
    reg_addr_e ext_a, sw_a;

    assign ext_a = reg_addr_e'(ext_addr);
    assign sw_a  = reg_addr_e'(sw_addr);

    always_comb begin
        r_d = r_q;
        // software side first, so that the external port wins a same-cycle collision
        if (sw_we) begin
            if (sw_a == A_CTRL && !r_q.ext_mode)
                r_d.int_mode = sw_wdata[CTRL_INT_BIT];
            if (sw_a == A_ENABLE)
                r_d.en = (r_q.en & hw_own) | (sw_wdata & ~hw_own);
        end
        if (ext_we) begin
            case (ext_a)
                A_CTRL: begin
                    r_d.ext_mode = ext_wdata[CTRL_EXT_BIT];
                    r_d.int_mode = ext_wdata[CTRL_INT_BIT];
                end
                A_ALLOC:  r_d.alloc = ext_wdata;
                A_ENABLE: r_d.en    = ext_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hw_own   = {NUM_RES{r_q.ext_mode}} & ~r_q.alloc;
    assign int_mode = r_q.int_mode;
    assign en       = r_q.en;
    assign ext_clr  = (ext_we && ext_a == A_STATUS) ? ext_wdata : '0;
    assign sw_clr   = (sw_we  && sw_a  == A_STATUS) ? sw_wdata  : '0;
    assign resume   = ext_we && ext_a == A_RESUME;

    // R7
    alloc_sw_proof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_we |=> $stable(r_q.alloc) && $stable(r_q.ext_mode));

    // R8
    hw_enable_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_we |=> ((r_q.en & $past(hw_own)) == ($past(r_q.en) & $past(hw_own))));

endmodule

// File: rtl/dbg_share_events.sv
module dbg_share_events #(
    parameter int NUM_RES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_RES-1:0] evt,
    input  logic [NUM_RES-1:0] en,
    input  logic [NUM_RES-1:0] hw_own,
    input  logic               int_mode,
    input  logic               msr_de,
    input  logic [NUM_RES-1:0] ext_clr,
    input  logic [NUM_RES-1:0] sw_clr,
    input  logic               resume,
    output logic [NUM_RES-1:0] status,
    output logic               irq,
    output logic               halt
);

    typedef struct packed {
        logic [NUM_RES-1:0] status;
        logic               halt;
    } ev_t;

    ev_t e_d, e_q;
    logic [NUM_RES-1:0] rec;
    logic [NUM_RES-1:0] clr;

    always_comb begin
        // hardware-owned events ignore the internal-mode bit
        rec = evt & en & (hw_own | {NUM_RES{int_mode}});
        clr = (ext_clr & hw_own) | (sw_clr & ~hw_own);
        e_d.status = (e_q.status & ~clr) | rec;
        e_d.halt   = (e_q.halt & ~resume) | (|(rec & hw_own));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign status = e_q.status;
    assign halt   = e_q.halt;
    assign irq    = msr_de & int_mode & (|(e_q.status & ~hw_own));

    // R5
    hw_event_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rec & hw_own)) |=> halt);

    // R11
    event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rec) |=> ((status & $past(rec)) == $past(rec)));

    // R12
    halt_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !resume) |=> halt);

    // R2
    idle_no_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_own == '0 && !int_mode && !(|clr)) |=> $stable(status));

endmodule

// File: rtl/dbg_share_ctrl.sv
module dbg_share_ctrl
    import dbg_share_pkg::*;
#(
    parameter int NUM_RES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_wr_en,
    input  logic               core_clk_en,
    input  logic [ADDR_W-1:0]  ext_addr,
    input  logic [NUM_RES-1:0] ext_wdata,
    input  logic               sw_wr_en,
    input  logic [ADDR_W-1:0]  sw_addr,
    input  logic [NUM_RES-1:0] sw_wdata,
    input  logic [NUM_RES-1:0] evt_i,
    input  logic               msr_de,
    output logic [NUM_RES-1:0] status_o,
    output logic               irq_o,
    output logic               halt_o
);

    logic               ext_we;
    logic               int_mode;
    logic [NUM_RES-1:0] hw_own, en, ext_clr, sw_clr;
    logic               resume;

    assign ext_we = ext_wr_en & core_clk_en;

    dbg_share_regs #(.NUM_RES(NUM_RES)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .sw_we(sw_wr_en), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .int_mode(int_mode), .hw_own(hw_own), .en(en),
        .ext_clr(ext_clr), .sw_clr(sw_clr), .resume(resume)
    );

    dbg_share_events #(.NUM_RES(NUM_RES)) i_events (
        .clk(clk), .rst_n(rst_n),
        .evt(evt_i), .en(en), .hw_own(hw_own), .int_mode(int_mode),
        .msr_de(msr_de), .ext_clr(ext_clr), .sw_clr(sw_clr), .resume(resume),
        .status(status_o), .irq(irq_o), .halt(halt_o)
    );

    // R9
    gated_ext_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_en && !sw_wr_en) |=> $stable(i_regs.hw_own));

endmodule

// File: tb/test_dbg_share_ctrl.sv
`timescale 1ns/1ps
module test_dbg_share_ctrl;
    localparam int N = 8;

    logic clk = 0, rst_n = 0;
    logic ext_wr_en = 0, core_clk_en = 1, sw_wr_en = 0, msr_de = 0;
    logic [2:0] ext_addr = 0, sw_addr = 0;
    logic [N-1:0] ext_wdata = 0, sw_wdata = 0, evt_i = 0;
    logic [N-1:0] status_o;
    logic irq_o, halt_o;

    int errors = 0, checks = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit m_ext, m_int, m_halt;
    bit m_alloc[N], m_en[N], m_st[N];

    always #2 clk = ~clk;

    dbg_share_ctrl #(.NUM_RES(N)) i_dbg_share_ctrl (.*);

    function automatic bit owned_by_hw(int i);
        return m_ext && !m_alloc[i];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ext = 0; m_int = 0; m_halt = 0;
            for (int i = 0; i < N; i++) begin m_alloc[i] = 0; m_en[i] = 0; m_st[i] = 0; end
        end else begin
            bit hw[N];
            bit n_ext, n_int, n_halt, ext_ok, any_hw_evt;
            bit n_alloc[N], n_en[N], n_st[N];
            ext_ok = ext_wr_en && core_clk_en;
            n_ext = m_ext; n_int = m_int; n_halt = m_halt; any_hw_evt = 0;
            for (int i = 0; i < N; i++) begin
                hw[i] = owned_by_hw(i);
                n_alloc[i] = m_alloc[i]; n_en[i] = m_en[i];
                // status: clear by owner, then event sets
                n_st[i] = m_st[i];
                if (hw[i] && ext_ok && ext_addr == 3 && ext_wdata[i]) n_st[i] = 0;
                if (!hw[i] && sw_wr_en && sw_addr == 3 && sw_wdata[i]) n_st[i] = 0;
                if (evt_i[i] && m_en[i] && (hw[i] || m_int)) begin
                    n_st[i] = 1;
                    if (hw[i]) any_hw_evt = 1;
                end
                if (sw_wr_en && sw_addr == 2 && !hw[i]) n_en[i] = sw_wdata[i];
                if (ext_ok && ext_addr == 2) n_en[i] = ext_wdata[i];
                if (ext_ok && ext_addr == 1) n_alloc[i] = ext_wdata[i];
            end
            if (sw_wr_en && sw_addr == 0 && !m_ext) n_int = sw_wdata[1];
            if (ext_ok && ext_addr == 0) begin n_ext = ext_wdata[0]; n_int = ext_wdata[1]; end
            if (ext_ok && ext_addr == 4) n_halt = 0;
            if (any_hw_evt) n_halt = 1;
            m_ext = n_ext; m_int = n_int; m_halt = n_halt;
            for (int i = 0; i < N; i++) begin
                m_alloc[i] = n_alloc[i]; m_en[i] = n_en[i]; m_st[i] = n_st[i];
            end
        end
    end

    task automatic compare();
        logic [N-1:0] exp_st;
        bit exp_irq;
        exp_irq = 0;
        for (int i = 0; i < N; i++) begin
            exp_st[i] = m_st[i];
            if (m_st[i] && !owned_by_hw(i)) exp_irq = 1;
        end
        exp_irq = exp_irq && msr_de && m_int;
        checks += 3;
        if (status_o !== exp_st) begin
            errors++; $display("FAIL %s status_o actual=%h expected=%h", cur_req, status_o, exp_st);
        end
        if (irq_o !== exp_irq) begin
            errors++; $display("FAIL %s irq_o actual=%b expected=%b", cur_req, irq_o, exp_irq);
        end
        if (halt_o !== m_halt) begin
            errors++; $display("FAIL %s halt_o actual=%b expected=%b", cur_req, halt_o, m_halt);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
        compare();
        ext_wr_en = 0; sw_wr_en = 0; evt_i = 0; core_clk_en = 1;
    endtask

    task automatic ext_wr(input logic [2:0] a, input logic [N-1:0] d);
        ext_wr_en = 1; ext_addr = a; ext_wdata = d; cyc();
    endtask

    task automatic sw_wr(input logic [2:0] a, input logic [N-1:0] d);
        sw_wr_en = 1; sw_addr = a; sw_wdata = d; cyc();
    endtask

    task automatic fire(input logic [N-1:0] e);
        evt_i = e; cyc();
    endtask

    task automatic expect_bits(input string tag, input logic [N-1:0] st, input bit irq, input bit hlt);
        checks++;
        if (status_o !== st || irq_o !== irq || halt_o !== hlt) begin
            errors++;
            $display("FAIL %s actual=%h/%b/%b expected=%h/%b/%b", tag, status_o, irq_o, halt_o, st, irq, hlt);
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cur_req = "R1"; cyc();
        expect_bits("R1", 8'h00, 0, 0);

        cur_req = "R2";
        ext_wr(2, 8'hFF);
        fire(8'hFF); msr_de = 1; fire(8'h0F);
        expect_bits("R2", 8'h00, 0, 0);

        cur_req = "R3";
        msr_de = 0;
        ext_wr(2, 8'h00);
        sw_wr(0, 8'h02); sw_wr(2, 8'h0F);
        fire(8'h11);
        expect_bits("R3", 8'h01, 0, 0);
        cur_req = "R4"; msr_de = 1; #0; cyc();
        expect_bits("R4", 8'h01, 1, 0);
        cur_req = "R10"; sw_wr(3, 8'h01);
        expect_bits("R10", 8'h00, 0, 0);

        cur_req = "R7";
        sw_wr(1, 8'hFF); sw_wr(0, 8'h03);
        cur_req = "R9";
        core_clk_en = 0; ext_wr_en = 1; ext_addr = 0; ext_wdata = 8'h03; cyc();
        fire(8'h80);
        cur_req = "R7"; fire(8'h02);
        expect_bits("R7", 8'h02, 1, 0);
        sw_wr(3, 8'hFF);

        cur_req = "R8";
        ext_wr(0, 8'h03); ext_wr(1, 8'h0F);
        sw_wr(0, 8'h00);
        sw_wr(2, 8'h00);
        ext_wr(2, 8'h0F);
        sw_wr(2, 8'hFF);
        fire(8'hF0);
        expect_bits("R8", 8'h00, 0, 0);
        ext_wr(2, 8'hFF);

        cur_req = "R5";
        msr_de = 0; fire(8'h30);
        expect_bits("R5", 8'h30, 0, 1);
        msr_de = 1; cyc();
        expect_bits("R5", 8'h30, 0, 1);
        cur_req = "R6"; fire(8'h01);
        expect_bits("R6", 8'h31, 1, 1);

        cur_req = "R10";
        sw_wr(3, 8'hFF);
        expect_bits("R10", 8'h30, 0, 1);
        ext_wr(3, 8'h11);
        cur_req = "R11";
        ext_wr_en = 1; ext_addr = 3; ext_wdata = 8'h20; evt_i = 8'h20; cyc();
        expect_bits("R11", 8'h20, 0, 1);
        sw_wr_en = 1; sw_addr = 3; sw_wdata = 8'h02; evt_i = 8'h02; cyc();
        expect_bits("R11", 8'h22, 1, 1);

        cur_req = "R12";
        core_clk_en = 0; ext_wr_en = 1; ext_addr = 4; cyc();
        expect_bits("R12", 8'h22, 1, 1);
        ext_wr_en = 1; ext_addr = 4; evt_i = 8'h40; cyc();
        expect_bits("R12", 8'h62, 1, 1);
        repeat (2) cyc();
        ext_wr(4, 8'h00);
        expect_bits("R12", 8'h62, 1, 0);

        cur_req = "R3";
        for (int k = 0; k < 600; k++) begin
            logic [31:0] r;
            r = $urandom;
            evt_i = r[7:0];
            msr_de = r[8];
            core_clk_en = r[9];
            ext_wr_en = (r[12:10] == 0);
            ext_addr = r[15:13] % 5;
            ext_wdata = r[23:16];
            sw_wr_en = r[24];
            sw_addr = r[27:25] % 5;
            sw_wdata = r[31:24] ^ r[7:0];
            cyc();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule